// File: doc/BRIEF.md
# Rectangle Copy Address Sequencer

This block drives the memory side of a rectangle copy in a frame buffer that is laid out as one continuous bit stream. Each memory word holds sixteen pixels, and the lowest bit is the leftmost pixel on screen. A scan line wraps to the next one after a fixed number of words, called the pitch. The caller gives the top-left pixel of the source and of the destination as flat pixel addresses counted from word 0. It also gives the rectangle width in pixels, the height in scan lines and the pitch in words, and then pulses `start`.

On the clock edge that takes `start`, the block splits each pixel address into a word address and a bit position. At the same time it derives the alignment shift, the destination edge masks and the number of words each line covers. These values are held for the whole operation so that the pixel datapath can use them.

The block then walks the destination rectangle one line at a time and one word at a time. It emits one memory request per cycle, tagged with its kind, and marks the first and the last word of every line so that the datapath knows when to apply the edge masks. A one-cycle `done` closes each operation.

Top module: `bbAddrSeq`

## Requirements
- R1: On the edge that accepts `start`, the block latches each pixel address as word = address >> 4 and bit = address & 15. `srcBit` and `dstBit` show the bit positions from the next cycle on.
- R2: `shiftAmt` equals (dstBit - srcBit) mod 16.
- R3: `leftMask` has bits dstBit..15 set. `rightMask` has bits 0..e set, where e = (dstBit + width - 1) mod 16. Neither mask, nor the shift, changes until the next accepted start.
- R4: `dstWords` = ((dstBit + width - 1) >> 4) + 1, and `srcWords` is computed the same way from srcBit.
- R5: For each destination word the block issues three requests on consecutive cycles, in this order: source read (`reqKind` 0), destination read (`reqKind` 1) and destination write (`reqKind` 2). `reqValid` is high on each of these cycles.
- R6: For word i of line L, the source request address is srcWord + L*pitch + i and both destination request addresses are dstWord + L*pitch + i. Addresses wrap modulo the word address width.
- R7: `firstWord` is high for the requests of word 0 of a line, and `lastWord` is high for those of word dstWords-1. On a one-word line both are high.
- R8: `busy` is high from the cycle after the accepted start through the `done` cycle. `done` is high for exactly one cycle, the cycle after the last write request, and `reqValid` is low in that cycle.
- R9: If the width or the height is zero, no request is issued and `done` is high in the cycle right after the accepted start.
- R10: A `start` raised while `busy` is high is ignored. The request sequence, the masks and the shift of the running operation are unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| srcPix | input | 24 | Source top-left pixel address |
| dstPix | input | 24 | Destination top-left pixel address |
| widthPix | input | 12 | Rectangle width in pixels |
| heightLines | input | 12 | Rectangle height in scan lines |
| pitchWords | input | 12 | Words per scan line |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| reqValid | output | 1 | A memory request is presented this cycle |
| reqKind | output | 2 | 0 source read, 1 destination read, 2 destination write |
| reqAddr | output | 20 | Word address of the request |
| firstWord | output | 1 | Request belongs to the leftmost word of the line |
| lastWord | output | 1 | Request belongs to the rightmost word of the line |
| shiftAmt | output | 4 | Source-to-destination alignment shift |
| leftMask | output | 16 | Mask for the leftmost destination word |
| rightMask | output | 16 | Mask for the rightmost destination word |
| srcBit | output | 4 | Source start bit within its word |
| dstBit | output | 4 | Destination start bit within its word |
| srcWords | output | 13 | Source words spanned per line |
| dstWords | output | 13 | Destination words per line |

## Verification
The bench aims at the corner cases around the edge words. It runs one-word lines, where a design that clears `lastWord` on the first word would drop the right mask. It runs widths that end exactly on bit 15, where an off-by-one in the end-bit arithmetic gives a right mask one bit short or a spare extra word. It also runs zero width and zero height, where a sequencer that checks only one of the two would issue a stray line. It drives addresses near the top of the word space to catch a carry that is not allowed to wrap. It raises `start` in the middle of an operation, which a careless idle test would treat as a restart that reloads the masks and corrupts the address stream.

// File: rtl/bbPkg.sv
package bbPkg;
  typedef enum logic [1:0] {
    REQ_SRC_RD = 2'd0,
    REQ_DST_RD = 2'd1,
    REQ_DST_WR = 2'd2
  } reqKind_t;

  typedef struct packed {
    logic load;      // capture operation parameters
    logic nextWord;  // step to next word in the line
    logic nextLine;  // step both bases by the pitch
  } bbStrobe_t;
endpackage

// File: rtl/bbCtrl.sv
module bbCtrl
  import bbPkg::*;
#(
  parameter int DIM_W = 12
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [DIM_W-1:0] widthPix,
  input  logic [DIM_W-1:0] heightLines,
  input  logic             lastWordIn,
  output bbStrobe_t        strobe,
  output logic             busy,
  output logic             done,
  output logic             reqValid,
  output reqKind_t         reqKind
);
  typedef enum logic [1:0] {S_IDLE, S_RUN, S_FIN} state_t;

  state_t           state;
  reqKind_t         phase;
  logic [DIM_W-1:0] linesLeft;
  logic             zeroDim;

  assign zeroDim  = (widthPix == '0) || (heightLines == '0);
  assign busy     = (state != S_IDLE);
  assign done     = (state == S_FIN);
  assign reqValid = (state == S_RUN);
  assign reqKind  = phase;

  always_comb begin
    strobe = '0;
    if (state == S_IDLE && start) strobe.load = 1'b1;
    if (state == S_RUN && phase == REQ_DST_WR) begin
      if (!lastWordIn)            strobe.nextWord = 1'b1;
      else if (linesLeft != '0)   strobe.nextLine = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      phase     <= REQ_SRC_RD;
      linesLeft <= '0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          phase     <= REQ_SRC_RD;
          linesLeft <= heightLines - DIM_W'(1);
          state     <= zeroDim ? S_FIN : S_RUN;
        end
        S_RUN: begin
          case (phase)
            REQ_SRC_RD: phase <= REQ_DST_RD;
            REQ_DST_RD: phase <= REQ_DST_WR;
            default: begin
              phase <= REQ_SRC_RD;
              if (lastWordIn) begin
                if (linesLeft == '0) state <= S_FIN;
                else linesLeft <= linesLeft - DIM_W'(1);
              end
            end
          endcase
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  // R8: completion pulse lasts one cycle
  p_done_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);
  // R9: empty rectangle finishes without requests
  p_zero_direct_r9: assert property (@(posedge clk) disable iff (!rstN)
    (state == S_IDLE && start && zeroDim) |=> (done && !reqValid));
  // R5: request order within a word
  p_order_src_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == REQ_SRC_RD) |=> (reqValid && reqKind == REQ_DST_RD));
  p_order_drd_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqKind == REQ_DST_RD) |=> (reqValid && reqKind == REQ_DST_WR));
  // R10: a start during a run does not cut the word short
  p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && start && reqKind != REQ_DST_WR) |=> reqValid);
endmodule

// File: rtl/bbPath.sv
module bbPath
  import bbPkg::*;
#(
  parameter int PIX_W   = 16,
  parameter int PADDR_W = 24,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 12,
  localparam int LOG     = $clog2(PIX_W),
  localparam int WADDR_W = PADDR_W - LOG,
  localparam int CNT_W   = DIM_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  bbStrobe_t          strobe,
  input  reqKind_t           reqKindIn,
  input  logic [PADDR_W-1:0] srcPix,
  input  logic [PADDR_W-1:0] dstPix,
  input  logic [DIM_W-1:0]   widthPix,
  input  logic [PITCH_W-1:0] pitchWords,
  output logic [WADDR_W-1:0] reqAddr,
  output logic               firstWord,
  output logic               lastWord,
  output logic [LOG-1:0]     shiftAmt,
  output logic [PIX_W-1:0]   leftMask,
  output logic [PIX_W-1:0]   rightMask,
  output logic [LOG-1:0]     srcBit,
  output logic [LOG-1:0]     dstBit,
  output logic [CNT_W-1:0]   srcWords,
  output logic [CNT_W-1:0]   dstWords
);
  localparam logic [PIX_W-1:0] ONES = {PIX_W{1'b1}};

  logic [LOG-1:0]     inSrcBit, inDstBit, inLastBit;
  logic [CNT_W-1:0]   inSrcSum, inDstSum;
  logic [WADDR_W-1:0] srcLine, dstLine;
  logic [PITCH_W-1:0] pitchR;
  logic [CNT_W-1:0]   wordOff;

  always_comb begin
    inSrcBit  = srcPix[LOG-1:0];
    inDstBit  = dstPix[LOG-1:0];
    inSrcSum  = CNT_W'(inSrcBit) + CNT_W'(widthPix) - CNT_W'(1);
    inDstSum  = CNT_W'(inDstBit) + CNT_W'(widthPix) - CNT_W'(1);
    inLastBit = inDstSum[LOG-1:0];
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      srcLine   <= '0;
      dstLine   <= '0;
      pitchR    <= '0;
      wordOff   <= '0;
      srcBit    <= '0;
      dstBit    <= '0;
      shiftAmt  <= '0;
      leftMask  <= '0;
      rightMask <= '0;
      srcWords  <= '0;
      dstWords  <= '0;
    end else if (strobe.load) begin
      srcLine   <= srcPix[PADDR_W-1:LOG];
      dstLine   <= dstPix[PADDR_W-1:LOG];
      pitchR    <= pitchWords;
      wordOff   <= '0;
      srcBit    <= inSrcBit;
      dstBit    <= inDstBit;
      shiftAmt  <= inDstBit - inSrcBit;
      leftMask  <= ONES << inDstBit;
      rightMask <= ONES >> (~inLastBit);
      srcWords  <= (inSrcSum >> LOG) + CNT_W'(1);
      dstWords  <= (inDstSum >> LOG) + CNT_W'(1);
    end else if (strobe.nextLine) begin
      wordOff <= '0;
      srcLine <= srcLine + WADDR_W'(pitchR);
      dstLine <= dstLine + WADDR_W'(pitchR);
    end else if (strobe.nextWord) begin
      wordOff <= wordOff + CNT_W'(1);
    end
  end

  assign reqAddr   = ((reqKindIn == REQ_SRC_RD) ? srcLine : dstLine) + WADDR_W'(wordOff);
  assign firstWord = (wordOff == '0);
  assign lastWord  = (wordOff == dstWords - CNT_W'(1));

  // R3: masks and shift only change on a load
  p_mask_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.load |=> ($stable(leftMask) && $stable(rightMask) && $stable(shiftAmt)));
  // R6: the write goes to the word just read from the destination
  p_wr_follows_rd_r6: assert property (@(posedge clk) disable iff (!rstN)
    (reqKindIn == REQ_DST_WR) |-> (reqAddr == $past(reqAddr)));
  // R7: a new line starts at its leftmost word
  p_first_word_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobe.nextLine |=> firstWord);
endmodule

// File: rtl/bbAddrSeq.sv
module bbAddrSeq
  import bbPkg::*;
#(
  parameter int PIX_W   = 16,
  parameter int PADDR_W = 24,
  parameter int DIM_W   = 12,
  parameter int PITCH_W = 12,
  localparam int LOG     = $clog2(PIX_W),
  localparam int WADDR_W = PADDR_W - LOG,
  localparam int CNT_W   = DIM_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               start,
  input  logic [PADDR_W-1:0] srcPix,
  input  logic [PADDR_W-1:0] dstPix,
  input  logic [DIM_W-1:0]   widthPix,
  input  logic [DIM_W-1:0]   heightLines,
  input  logic [PITCH_W-1:0] pitchWords,
  output logic               busy,
  output logic               done,
  output logic               reqValid,
  output logic [1:0]         reqKind,
  output logic [WADDR_W-1:0] reqAddr,
  output logic               firstWord,
  output logic               lastWord,
  output logic [LOG-1:0]     shiftAmt,
  output logic [PIX_W-1:0]   leftMask,
  output logic [PIX_W-1:0]   rightMask,
  output logic [LOG-1:0]     srcBit,
  output logic [LOG-1:0]     dstBit,
  output logic [CNT_W-1:0]   srcWords,
  output logic [CNT_W-1:0]   dstWords
);
  bbStrobe_t strobe;
  reqKind_t  kind;
  logic      lastW;

  bbCtrl #(.DIM_W(DIM_W)) uCtrl (
    .clk(clk), .rstN(rstN), .start(start),
    .widthPix(widthPix), .heightLines(heightLines),
    .lastWordIn(lastW), .strobe(strobe),
    .busy(busy), .done(done), .reqValid(reqValid), .reqKind(kind)
  );

  bbPath #(.PIX_W(PIX_W), .PADDR_W(PADDR_W), .DIM_W(DIM_W), .PITCH_W(PITCH_W)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe), .reqKindIn(kind),
    .srcPix(srcPix), .dstPix(dstPix), .widthPix(widthPix), .pitchWords(pitchWords),
    .reqAddr(reqAddr), .firstWord(firstWord), .lastWord(lastW),
    .shiftAmt(shiftAmt), .leftMask(leftMask), .rightMask(rightMask),
    .srcBit(srcBit), .dstBit(dstBit), .srcWords(srcWords), .dstWords(dstWords)
  );

  assign reqKind  = kind;
  assign lastWord = lastW;
endmodule

// File: tb/sim_bbAddrSeq.sv
module sim_bbAddrSeq;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        start = 1'b0;
  logic [23:0] srcPix = '0, dstPix = '0;
  logic [11:0] widthPix = '0, heightLines = '0, pitchWords = '0;
  logic        busy, done, reqValid, firstWord, lastWord;
  logic [1:0]  reqKind;
  logic [19:0] reqAddr;
  logic [3:0]  shiftAmt, srcBit, dstBit;
  logic [15:0] leftMask, rightMask;
  logic [12:0] srcWords, dstWords;

  int vectors = 0;
  int errors  = 0;

  always #10 clk = ~clk;

  bbAddrSeq u0 (
    .clk(clk), .rstN(rstN), .start(start), .srcPix(srcPix), .dstPix(dstPix),
    .widthPix(widthPix), .heightLines(heightLines), .pitchWords(pitchWords),
    .busy(busy), .done(done), .reqValid(reqValid), .reqKind(reqKind),
    .reqAddr(reqAddr), .firstWord(firstWord), .lastWord(lastWord),
    .shiftAmt(shiftAmt), .leftMask(leftMask), .rightMask(rightMask),
    .srcBit(srcBit), .dstBit(dstBit), .srcWords(srcWords), .dstWords(dstWords)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    vectors++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [15:0] expLeft(input int db);
    return 16'hFFFF << db;
  endfunction
  function automatic logic [15:0] expRight(input int db, input int w);
    return 16'hFFFF >> (15 - ((db + w - 1) & 15));
  endfunction
  function automatic int expWords(input int b, input int w);
    return ((b + w - 1) >> 4) + 1;
  endfunction

  task automatic runOp(input logic [23:0] s, input logic [23:0] d, input int w,
                       input int h, input int p, input bit poke);
    int sb = int'(s[3:0]);
    int db = int'(d[3:0]);
    int sw = int'(s[23:4]);
    int dw = int'(d[23:4]);
    int nw = expWords(db, w);
    logic [15:0] eL = expLeft(db);
    logic [15:0] eR = expRight(db, w);
    logic [3:0]  eS = 4'(db - sb);
    @(negedge clk);
    srcPix = s; dstPix = d; widthPix = 12'(w); heightLines = 12'(h);
    pitchWords = 12'(p); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (w == 0 || h == 0) begin
      chk(done && !reqValid && busy, "R9 zero-size done", {done, reqValid, busy}, 3'b101);
      @(negedge clk);
      chk(!done && !busy && !reqValid, "R8 idle after done", {done, busy}, 0);
      return;
    end
    chk(srcBit == 4'(sb) && dstBit == 4'(db), "R1 bit split", {srcBit, dstBit}, {4'(sb), 4'(db)});
    chk(shiftAmt == eS, "R2 shift", shiftAmt, eS);
    chk(leftMask == eL && rightMask == eR, "R3 masks", {leftMask, rightMask}, {eL, eR});
    chk(dstWords == 13'(nw) && srcWords == 13'(expWords(sb, w)), "R4 word counts",
        {dstWords, srcWords}, {13'(nw), 13'(expWords(sb, w))});
    for (int ln = 0; ln < h; ln++) begin
      for (int i = 0; i < nw; i++) begin
        for (int k = 0; k < 3; k++) begin
          logic [19:0] ea = 20'(((k == 0) ? sw : dw) + ln * p + i);
          chk(reqValid && busy && !done && reqKind == 2'(k), "R5 request kind",
              {reqValid, reqKind}, {1'b1, 2'(k)});
          chk(reqAddr == ea, "R6 address", reqAddr, ea);
          chk(firstWord == (i == 0) && lastWord == (i == nw - 1), "R7 edge flags",
              {firstWord, lastWord}, {(i == 0), (i == nw - 1)});
          if (poke && ln == 0 && i == 0 && k == 0) begin
            srcPix = ~s; dstPix = ~d; widthPix = 12'(w + 7); heightLines = 12'd0;
            start = 1'b1;
          end else begin
            start = 1'b0;
          end
          @(negedge clk);
        end
      end
    end
    chk(done && !reqValid && busy, "R8 done after last write", {done, reqValid, busy}, 3'b101);
    if (poke)
      chk(leftMask == eL && rightMask == eR && shiftAmt == eS, "R10 start ignored",
          {leftMask, rightMask, shiftAmt}, {eL, eR, eS});
    @(negedge clk);
    chk(!done && !busy, "R8 single-cycle done", {done, busy}, 0);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    chk(!busy && !done && !reqValid, "R8 reset state", {busy, done, reqValid}, 0);
    rstN = 1'b1;
    // worked example: two words per line, shift 3
    runOp(24'h000021, 24'h000204, 'h13, 6, 2, 1'b0);
    chk(leftMask == 16'hFFF0 && rightMask == 16'h007F, "R3 example masks",
        {leftMask, rightMask}, {16'hFFF0, 16'h007F});
    runOp(24'h000105, 24'h000043, 3, 2, 4, 1'b0);   // single word per line
    runOp(24'h000010, 24'h000020, 16, 3, 2, 1'b0);  // exactly one full word
    runOp(24'h000007, 24'h000031, 15, 2, 3, 1'b0);  // ends on bit 15
    runOp(24'h000050, 24'h000060, 0, 4, 2, 1'b0);   // zero width
    runOp(24'h000050, 24'h000060, 9, 0, 2, 1'b0);   // zero height
    runOp(24'hFFFFF3, 24'hFFFFE9, 40, 3, 5, 1'b0);  // address wrap
    runOp(24'h000123, 24'h000456, 30, 3, 6, 1'b1);  // start while busy
    for (int n = 0; n < 60; n++) begin
      runOp(24'($urandom), 24'($urandom), int'($urandom % 41),
            int'($urandom % 5), 1 + int'($urandom % 8), ($urandom % 4) == 0);
    end
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end
endmodule